// File: doc/BRIEF.md
# Priority Task Queue Controller

This controller maintains an ordered list of tasks in an external single-port synchronous byte RAM and executes one command per start/done handshake. Each stored entry is one byte carrying a task identifier and a two-bit priority. Smaller priority values are served first. Among entries with the same priority, the oldest is served first.

A host places an opcode, a task identifier and a priority on the inputs and raises `start`. The controller walks the RAM through its own port, one access per cycle. Read data returns one cycle after an enabled read. When every write of the command has been issued, the controller raises `done`. The four commands are:

- insert a task;
- remove the head, reporting its identifier;
- clear the queue;
- age every stored priority by one step.

Top module: `task_pq_ctrl`

## Requirements
- R1: After reset, `done` is low. The controller writes 0 to RAM address 0 before it accepts its first command.
- R2: Address 0 holds the entry count. Entries sit at consecutive addresses from 1, with the head at address 1. In each entry byte, bits 7..2 are the task id and bits 1..0 are the priority. No write goes above address MAX_DEPTH.
- R3: Opcode 2'b10 inserts {id, priority}. The new entry goes after every entry whose priority is less than or equal to its own, so equal priorities stay in arrival order. The count then rises by 1.
- R4: An insert issued while the count equals MAX_DEPTH leaves the count and all entries unchanged.
- R5: Opcode 2'b01 puts the head's task id on `out_id`. It moves every later entry down one address and lowers the count by 1.
- R6: Opcode 2'b01 on an empty queue puts 0 on `out_id` and leaves the count and all RAM bytes unchanged.
- R7: Opcode 2'b11 writes 0 to the count byte, which empties the queue.
- R8: Opcode 2'b00 raises the priority field of every stored entry by 1, stopping at 3. Ids, order and count do not change.
- R9: `done` rises only after the command's last write. It stays high while `start` is held high, falls in the cycle after `start` falls, and no RAM access occurs while `done` is high.
- R10: `out_id` changes only as the result of a remove command and holds its value through all other commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| start | input | 1 | Command request, held until `done` |
| task_id | input | 6 | Task identifier for insert |
| task_pri | input | 2 | Priority for insert (0 = most urgent) |
| opcode | input | 2 | 00 age, 01 remove, 10 insert, 11 clear |
| done | output | 1 | Command complete |
| out_id | output | 6 | Identifier of the last removed task |
| mem_addr | output | 16 | RAM address |
| mem_rdata | input | 8 | RAM read data, valid one cycle after a read |
| mem_wdata | output | 8 | RAM write data |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable |

## Verification
The bench builds the controller with MAX_DEPTH = 4, so a few inserts fill the queue. This brings the full-queue refusal, a remove that shifts three entries, and saturation of several aged entries into a short run. Default widths are kept so that entry bytes match the real packing. A queue model in the bench predicts the RAM image and `out_id` after every command. It also watches the RAM port every cycle for out-of-range writes and for accesses made while `done` is high.

// File: rtl/task_pq_pkg.sv
package task_pq_pkg;

    typedef enum logic [3:0] {
        S_INIT,
        S_IDLE,
        S_RDCNT,
        S_DISP,
        S_CLR,
        S_INS_RD,
        S_INS_CHK,
        S_INS_CNT,
        S_RM_HEAD,
        S_RM_HV,
        S_RM_RD,
        S_RM_MV,
        S_RM_CNT,
        S_AG_RD,
        S_AG_WR,
        S_DONE
    } tpq_state_e;

    localparam logic [1:0] OP_AGE  = 2'b00;
    localparam logic [1:0] OP_POP  = 2'b01;
    localparam logic [1:0] OP_PUSH = 2'b10;
    localparam logic [1:0] OP_CLR  = 2'b11;

endpackage

// File: rtl/tpq_age.sv
module tpq_age #(
    parameter int ID_W  = 6,
    parameter int PRI_W = 2
) (
    input  logic [ID_W+PRI_W-1:0] ent_i,
    output logic [ID_W+PRI_W-1:0] ent_o
);
    localparam int          DATA_W  = ID_W + PRI_W;
    localparam logic [PRI_W-1:0] PRI_MAX = '1;

    logic [PRI_W-1:0] pri;

    always_comb begin
        pri   = ent_i[PRI_W-1:0];
        ent_o = {ent_i[DATA_W-1:PRI_W], (pri == PRI_MAX) ? pri : pri + 1'b1};
    end
endmodule

// File: rtl/tpq_slot_cmp.sv
module tpq_slot_cmp #(
    parameter int ID_W  = 6,
    parameter int PRI_W = 2
) (
    input  logic [ID_W+PRI_W-1:0] stored_i,
    input  logic [PRI_W-1:0]      new_pri_i,
    output logic                  place_above_o
);
    // New entry settles directly above a stored entry of lower or equal value.
    always_comb begin
        place_above_o = (stored_i[PRI_W-1:0] <= new_pri_i);
    end
endmodule

// File: rtl/task_pq_ctrl.sv
module task_pq_ctrl
    import task_pq_pkg::*;
#(
    parameter int ID_W      = 6,
    parameter int PRI_W     = 2,
    parameter int ADDR_W    = 16,
    parameter int MAX_DEPTH = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [ID_W-1:0]       task_id,
    input  logic [PRI_W-1:0]      task_pri,
    input  logic [1:0]            opcode,
    output logic                  done,
    output logic [ID_W-1:0]       out_id,
    output logic [ADDR_W-1:0]     mem_addr,
    input  logic [ID_W+PRI_W-1:0] mem_rdata,
    output logic [ID_W+PRI_W-1:0] mem_wdata,
    output logic                  mem_en,
    output logic                  mem_we
);
    localparam int DATA_W = ID_W + PRI_W;
    localparam int IDX_W  = $clog2(MAX_DEPTH + 2);
    localparam logic [ADDR_W-1:0] CNT_ADDR  = '0;
    localparam logic [ADDR_W-1:0] HEAD_ADDR = ADDR_W'(1);
    localparam logic [DATA_W-1:0] DEPTH_LIM = DATA_W'(MAX_DEPTH);

    typedef struct packed {
        tpq_state_e        state;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] cnt;
        logic [1:0]        op;
        logic [ID_W-1:0]   id;
        logic [PRI_W-1:0]  pri;
        logic [ID_W-1:0]   out_id;
    } regs_t;

    regs_t r_d, r_q;

    logic [DATA_W-1:0] aged_ent;
    logic              place_above;
    logic [ADDR_W-1:0] idx_addr;
    logic              idx_past_cnt;

    tpq_age #(.ID_W(ID_W), .PRI_W(PRI_W)) u_age (
        .ent_i (mem_rdata),
        .ent_o (aged_ent)
    );

    tpq_slot_cmp #(.ID_W(ID_W), .PRI_W(PRI_W)) u_slot (
        .stored_i      (mem_rdata),
        .new_pri_i     (r_q.pri),
        .place_above_o (place_above)
    );

    always_comb begin
        idx_addr     = ADDR_W'(r_q.idx);
        idx_past_cnt = (ADDR_W'(r_q.idx) > ADDR_W'(r_q.cnt));
    end

    always_comb begin
        r_d       = r_q;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = CNT_ADDR;
        mem_wdata = '0;

        unique case (r_q.state)
            S_INIT: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = CNT_ADDR;
                mem_wdata = '0;
                r_d.state = S_IDLE;
            end
            S_IDLE: begin
                if (start) begin
                    r_d.op    = opcode;
                    r_d.id    = task_id;
                    r_d.pri   = task_pri;
                    r_d.state = S_RDCNT;
                end
            end
            S_RDCNT: begin
                mem_en    = 1'b1;
                mem_addr  = CNT_ADDR;
                r_d.state = S_DISP;
            end
            S_DISP: begin
                r_d.cnt = mem_rdata;
                unique case (r_q.op)
                    OP_CLR:  r_d.state = S_CLR;
                    OP_PUSH: begin
                        if (mem_rdata >= DEPTH_LIM) begin
                            r_d.state = S_DONE;
                        end else begin
                            r_d.idx   = IDX_W'(mem_rdata);
                            r_d.state = S_INS_RD;
                        end
                    end
                    OP_POP: begin
                        if (mem_rdata == '0) begin
                            r_d.out_id = '0;
                            r_d.state  = S_DONE;
                        end else begin
                            r_d.state = S_RM_HEAD;
                        end
                    end
                    default: begin
                        r_d.idx   = IDX_W'(1);
                        r_d.state = S_AG_RD;
                    end
                endcase
            end
            S_CLR: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = CNT_ADDR;
                mem_wdata = '0;
                r_d.state = S_DONE;
            end
            S_INS_RD: begin
                mem_en = 1'b1;
                if (r_q.idx == '0) begin
                    mem_we    = 1'b1;
                    mem_addr  = HEAD_ADDR;
                    mem_wdata = {r_q.id, r_q.pri};
                    r_d.state = S_INS_CNT;
                end else begin
                    mem_addr  = idx_addr;
                    r_d.state = S_INS_CHK;
                end
            end
            S_INS_CHK: begin
                mem_en   = 1'b1;
                mem_we   = 1'b1;
                mem_addr = idx_addr + 1'b1;
                if (place_above) begin
                    mem_wdata = {r_q.id, r_q.pri};
                    r_d.state = S_INS_CNT;
                end else begin
                    mem_wdata = mem_rdata;
                    r_d.idx   = r_q.idx - 1'b1;
                    r_d.state = S_INS_RD;
                end
            end
            S_INS_CNT: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = CNT_ADDR;
                mem_wdata = r_q.cnt + 1'b1;
                r_d.state = S_DONE;
            end
            S_RM_HEAD: begin
                mem_en    = 1'b1;
                mem_addr  = HEAD_ADDR;
                r_d.state = S_RM_HV;
            end
            S_RM_HV: begin
                r_d.out_id = mem_rdata[DATA_W-1:PRI_W];
                r_d.idx    = IDX_W'(2);
                r_d.state  = S_RM_RD;
            end
            S_RM_RD: begin
                if (idx_past_cnt) begin
                    r_d.state = S_RM_CNT;
                end else begin
                    mem_en    = 1'b1;
                    mem_addr  = idx_addr;
                    r_d.state = S_RM_MV;
                end
            end
            S_RM_MV: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = idx_addr - 1'b1;
                mem_wdata = mem_rdata;
                r_d.idx   = r_q.idx + 1'b1;
                r_d.state = S_RM_RD;
            end
            S_RM_CNT: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = CNT_ADDR;
                mem_wdata = r_q.cnt - 1'b1;
                r_d.state = S_DONE;
            end
            S_AG_RD: begin
                if (idx_past_cnt) begin
                    r_d.state = S_DONE;
                end else begin
                    mem_en    = 1'b1;
                    mem_addr  = idx_addr;
                    r_d.state = S_AG_WR;
                end
            end
            S_AG_WR: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = idx_addr;
                mem_wdata = aged_ent;
                r_d.idx   = r_q.idx + 1'b1;
                r_d.state = S_AG_RD;
            end
            S_DONE: begin
                if (!start) r_d.state = S_IDLE;
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            r_q       <= '0;
            r_q.state <= S_INIT;
        end else begin
            r_q <= r_d;
        end
    end

    assign done   = (r_q.state == S_DONE);
    assign out_id = r_q.out_id;

endmodule

// File: rtl/task_pq_checker.sv
module task_pq_checker #(
    parameter int ID_W      = 6,
    parameter int ADDR_W    = 16,
    parameter int MAX_DEPTH = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              done,
    input logic [ID_W-1:0]   out_id,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_en,
    input logic              mem_we
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(MAX_DEPTH);

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_en);                                        // R9
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> done);                                // R9
    AST_DONE_DROP: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !done);                              // R9
    AST_WR_RANGE: assert property (@(posedge clk) disable iff (rst)
        (mem_en && mem_we) |-> (mem_addr <= TOP_ADDR));           // R2
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        done |=> $stable(out_id));                                // R10
endmodule

bind task_pq_ctrl task_pq_checker #(
    .ID_W(ID_W), .ADDR_W(ADDR_W), .MAX_DEPTH(MAX_DEPTH)
) u_chk (
    .clk(clk), .rst(rst), .start(start), .done(done), .out_id(out_id),
    .mem_addr(mem_addr), .mem_en(mem_en), .mem_we(mem_we)
);

// File: tb/task_pq_ctrl_tb.sv
`timescale 1ns/1ps
module task_pq_ctrl_tb;
    localparam int MAXD = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [5:0] task_id = '0;
    logic [1:0] task_pri = '0;
    logic [1:0] opcode = '0;
    logic       done;
    logic [5:0] out_id;
    logic [15:0] mem_addr;
    logic [7:0] mem_rdata = '0;
    logic [7:0] mem_wdata;
    logic       mem_en, mem_we;

    logic [7:0] ram [0:255];
    logic [7:0] model[$];
    logic [5:0] exp_out = '0;
    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    task_pq_ctrl #(.MAX_DEPTH(MAXD)) u_dut (
        .clk(clk), .rst(rst), .start(start), .task_id(task_id),
        .task_pri(task_pri), .opcode(opcode), .done(done), .out_id(out_id),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
        .mem_en(mem_en), .mem_we(mem_we)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
            else        mem_rdata <= ram[mem_addr[7:0]];
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Every-clock port monitor
    always @(negedge clk) begin
        if (!rst && mem_en && mem_we && mem_addr > MAXD) begin
            fails++;
            $display("FAIL R2 write address actual=%0d expected<=%0d", mem_addr, MAXD);
        end
        if (!rst && done && mem_en) begin
            fails++;
            $display("FAIL R9 access while done actual=1 expected=0");
        end
    end

    task automatic compare_image(input string req);
        check(ram[0] == 8'(model.size()), {req, " count"}, ram[0], model.size());
        foreach (model[i])
            check(ram[i+1] == model[i], {req, " entry"}, ram[i+1], model[i]);
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic [5:0] id,
                           input logic [1:0] pr, input string req);
        int n;
        @(negedge clk);
        opcode = op; task_id = id; task_pri = pr; start = 1'b1;
        n = 0;
        while (!done && n < 500) begin @(negedge clk); n++; end
        check(done, {req, " done"}, done, 1);
        // model update
        case (op)
            2'b10: if (model.size() < MAXD) begin
                int pos = model.size();
                for (int i = model.size() - 1; i >= 0; i--)
                    if (model[i][1:0] > pr) pos = i;
                model.insert(pos, {id, pr});
            end
            2'b01: if (model.size() == 0) exp_out = '0;
                   else begin exp_out = model[0][7:2]; model.delete(0); end
            2'b11: model.delete();
            default: foreach (model[i])
                if (model[i][1:0] != 2'b11) model[i][1:0] = model[i][1:0] + 2'b01;
        endcase
        compare_image(req);
        check(out_id == exp_out, {req, " out_id"}, out_id, exp_out);
        @(negedge clk);
        check(done, "R9 done held while start high", done, 1);
        start = 1'b0;
        @(negedge clk);
        check(!done, "R9 done falls after start", done, 0);
    endtask

    initial begin
        logic [7:0] snap [0:MAXD];
        for (int i = 0; i < 256; i++) ram[i] = 8'hFF;
        repeat (3) @(negedge clk);
        check(!done, "R1 done low in reset", done, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check(!done, "R1 done low after reset", done, 0);
        check(ram[0] == 8'd0, "R1 count initialised", ram[0], 0);

        run_cmd(2'b10, 6'd1, 2'd1, "R3 first insert");
        check(ram[1] == 8'h05, "R2 entry packing", ram[1], 8'h05);
        run_cmd(2'b11, 6'd0, 2'd0, "R7 clear");
        run_cmd(2'b10, 6'd1, 2'd1, "R3 insert");
        run_cmd(2'b10, 6'd2, 2'd1, "R3 equal priority fifo");
        run_cmd(2'b10, 6'd3, 2'd2, "R3 insert tail");
        run_cmd(2'b10, 6'd4, 2'd0, "R3 insert head");
        run_cmd(2'b10, 6'd5, 2'd0, "R4 insert when full");
        run_cmd(2'b01, 6'd0, 2'd0, "R5 remove head");
        run_cmd(2'b00, 6'd0, 2'd0, "R8 age");
        check(out_id == 6'd4, "R10 out_id held after age", out_id, 4);
        run_cmd(2'b00, 6'd0, 2'd0, "R8 age saturating");
        run_cmd(2'b10, 6'd9, 2'd3, "R10 insert keeps out_id");
        check(out_id == 6'd4, "R10 out_id held after insert", out_id, 4);
        run_cmd(2'b01, 6'd0, 2'd0, "R5 remove");
        run_cmd(2'b01, 6'd0, 2'd0, "R5 remove");
        run_cmd(2'b01, 6'd0, 2'd0, "R5 remove");
        run_cmd(2'b01, 6'd0, 2'd0, "R5 remove last");
        for (int i = 0; i <= MAXD; i++) snap[i] = ram[i];
        run_cmd(2'b01, 6'd0, 2'd0, "R6 remove empty");
        for (int i = 0; i <= MAXD; i++)
            check(ram[i] == snap[i], "R6 ram unchanged", ram[i], snap[i]);
        run_cmd(2'b10, 6'd7, 2'd3, "R3 insert");
        run_cmd(2'b10, 6'd8, 2'd3, "R3 fifo among lowest");
        run_cmd(2'b10, 6'd10, 2'd2, "R3 insert before weaker");
        run_cmd(2'b00, 6'd0, 2'd0, "R8 age mixed");
        run_cmd(2'b01, 6'd0, 2'd0, "R5 remove after age");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule